// File: doc/BRIEF.md
# DMA Request Latch and Bus Arbiter

This block holds one pending-request flag for each of four DMA channels and decides, cycle by cycle, whether the shared bus belongs to the CPU or to one DMA channel. Each channel's flag is raised either by a one-cycle internal event pulse or by an edge on that channel's own external trigger pin. A per-channel select input picks the source. A per-channel polarity input picks whether the pin fires on its rising or its falling edge. Pin inputs are resynchronised to the clock before their edges are detected.

The CPU owns the bus by default. Arbitration takes place only at a CPU bus-access boundary, which the CPU marks with `cpu_access_done_i`. At that boundary, the lowest-numbered channel that is both enabled and pending wins. The block raises that channel's grant and emits a one-cycle start strobe, and the channel's request flag is cleared on the same edge. The grant stays asserted until `dma_xfer_done_i` arrives. The bus then goes back to the CPU, and the CPU must complete one more access before any channel is granted again. As a result, two DMA transfers are always separated by at least one CPU access. Address generation, transfer counting and data movement are handled elsewhere.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `cpu_gnt_o` is 1, and `dma_gnt_o`, `req_pend_o` and `xfer_start_o` are all 0.
- R2: When `src_ext_i[c]` is 0, a high `int_evt_i[c]` sampled at a clock edge sets `req_pend_o[c]` after that edge, and the pin of channel c has no effect. When `src_ext_i[c]` is 1, `int_evt_i[c]` has no effect.
- R3: When `src_ext_i[c]` is 1, an edge on `ext_pin_i[c]` sets `req_pend_o[c]`. The edge is falling when `pol_rise_i[c]` is 0 and rising when it is 1. The flag becomes visible after the third rising clock edge following the pin change. The opposite edge has no effect.
- R4: Triggers on several channels in the same clock cycle set all of their request flags on the same edge, for internal and external sources alike.
- R5: A grant is issued only at an edge where the CPU owns the bus and `cpu_access_done_i` is 1. The grant goes to the lowest-indexed channel whose request flag and `ch_en_i` bit are both 1. `dma_gnt_o` is one-hot or zero, and `cpu_gnt_o` is 1 exactly when `dma_gnt_o` is zero.
- R6: On the edge that issues a grant, the granted channel's request flag clears. `xfer_start_o` is 1 only in the first cycle of the grant.
- R7: A pending request on a channel whose `ch_en_i` bit is 0 stays latched and is never granted. It is granted once the channel is enabled.
- R8: A grant holds until `dma_xfer_done_i` is 1. The bus then returns to the CPU on the next cycle. `cpu_access_done_i` during a transfer is ignored, and the next grant needs a fresh `cpu_access_done_i` while the CPU owns the bus.
- R9: A trigger for a channel that arrives on its grant edge or during its transfer stays latched and is granted later.
- R10: `dma_xfer_done_i` while the CPU owns the bus has no effect on the grants or on the request flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_evt_i | input | 4 | Internal trigger pulse per channel |
| ext_pin_i | input | 4 | Asynchronous external trigger pin per channel |
| src_ext_i | input | 4 | Source select per channel: 1 selects the pin, 0 the internal event |
| pol_rise_i | input | 4 | Pin edge per channel: 1 selects rising, 0 falling |
| ch_en_i | input | 4 | Channel enable for arbitration |
| cpu_access_done_i | input | 1 | CPU bus-access boundary strobe |
| dma_xfer_done_i | input | 1 | End of the current DMA transfer |
| dma_gnt_o | output | 4 | One-hot DMA channel grant |
| cpu_gnt_o | output | 1 | CPU owns the bus |
| xfer_start_o | output | 1 | Pulse in the first cycle of a grant |
| req_pend_o | output | 4 | Latched request flags |

## Verification
Two events can fall on the same clock edge: a request flag being cleared because its channel is granted, and a new trigger arriving for that same channel. The bench provokes this by pulsing the channel's internal event in the cycle that carries `cpu_access_done_i`. It then checks that the flag reads 1 right after the grant, and that the channel is granted a second time after the CPU access that must come in between. The second overlap is triggers from several channels in one cycle. The bench sweeps every request mask against every enable mask. For each pair it checks that the whole mask latches at once and that the enabled channels drain in ascending index order. It also checks that the disabled channels are left behind.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_DMA = 1'b1
  } bus_owner_e;
endpackage

// File: rtl/dma_pin_trig.sv
module dma_pin_trig #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pin_i,
  input  logic [N_CH-1:0] pol_rise_i,
  output logic [N_CH-1:0] edge_o
);
  localparam int LastStage = SYNC_STAGES - 1;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i[g]};
        prev_q <= sync_q[LastStage];
      end
    end

    assign cur       = sync_q[LastStage];
    assign edge_o[g] = pol_rise_i[g] ? (cur & ~prev_q) : (~cur & prev_q);
  end
endmodule

// File: rtl/dma_req_bits.sv
module dma_req_bits #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] req_o
);
  logic [N_CH-1:0] req_q;

  // a set that arrives on the clearing edge wins, so the new request survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~clr_i) | set_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] en_i,
  input  logic            cpu_access_done_i,
  input  logic            dma_xfer_done_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            cpu_gnt_o,
  output logic            start_o,
  output logic [N_CH-1:0] clr_o
);
  bus_owner_e      owner_q;
  logic [N_CH-1:0] gnt_q;
  logic            start_q;
  logic [N_CH-1:0] eligible;
  logic [N_CH-1:0] pick;
  logic            launch;

  assign eligible = req_i & en_i;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign launch = (owner_q == OWN_CPU) && cpu_access_done_i && (|eligible);
  assign clr_o  = launch ? pick : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_CPU;
      gnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      unique case (owner_q)
        OWN_CPU: if (launch) begin
          owner_q <= OWN_DMA;
          gnt_q   <= pick;
        end
        OWN_DMA: if (dma_xfer_done_i) begin
          owner_q <= OWN_CPU;
          gnt_q   <= '0;
        end
        default: begin
          owner_q <= OWN_CPU;
          gnt_q   <= '0;
        end
      endcase
    end
  end

  assign gnt_o     = gnt_q;
  assign cpu_gnt_o = (owner_q == OWN_CPU);
  assign start_o   = start_q;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] int_evt_i,
  input  logic [N_CH-1:0] ext_pin_i,
  input  logic [N_CH-1:0] src_ext_i,
  input  logic [N_CH-1:0] pol_rise_i,
  input  logic [N_CH-1:0] ch_en_i,
  input  logic            cpu_access_done_i,
  input  logic            dma_xfer_done_i,
  output logic [N_CH-1:0] dma_gnt_o,
  output logic            cpu_gnt_o,
  output logic            xfer_start_o,
  output logic [N_CH-1:0] req_pend_o
);
  logic [N_CH-1:0] pin_edge;
  logic [N_CH-1:0] trig;
  logic [N_CH-1:0] req;
  logic [N_CH-1:0] clr;

  dma_pin_trig #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .pol_rise_i (pol_rise_i),
    .edge_o     (pin_edge)
  );

  assign trig = (src_ext_i & pin_edge) | (~src_ext_i & int_evt_i);

  dma_req_bits #(.N_CH(N_CH)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig),
    .clr_i  (clr),
    .req_o  (req)
  );

  dma_bus_arb #(.N_CH(N_CH)) u_arb (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .req_i             (req),
    .en_i              (ch_en_i),
    .cpu_access_done_i (cpu_access_done_i),
    .dma_xfer_done_i   (dma_xfer_done_i),
    .gnt_o             (dma_gnt_o),
    .cpu_gnt_o         (cpu_gnt_o),
    .start_o           (xfer_start_o),
    .clr_o             (clr)
  );

  assign req_pend_o = req;
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] ch_en_i,
  input logic            cpu_access_done_i,
  input logic            dma_xfer_done_i,
  input logic [N_CH-1:0] dma_gnt_o,
  input logic            cpu_gnt_o,
  input logic            xfer_start_o,
  input logic [N_CH-1:0] req_pend_o
);
  assert_gnt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dma_gnt_o) && (cpu_gnt_o == (dma_gnt_o == '0)));

  assert_no_grant_off_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o && !cpu_access_done_i |=> cpu_gnt_o);

  assert_start_on_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o && cpu_access_done_i && ((req_pend_o & ch_en_i) != '0) |=> xfer_start_o && !cpu_gnt_o);

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  assert_enabled_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o && cpu_access_done_i |=> ((dma_gnt_o & ~$past(ch_en_i)) == '0));

  assert_grant_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_gnt_o && !dma_xfer_done_i |=> $stable(dma_gnt_o));

  assert_return_cpu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_gnt_o && dma_xfer_done_i |=> cpu_gnt_o);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .ch_en_i           (ch_en_i),
  .cpu_access_done_i (cpu_access_done_i),
  .dma_xfer_done_i   (dma_xfer_done_i),
  .dma_gnt_o         (dma_gnt_o),
  .cpu_gnt_o         (cpu_gnt_o),
  .xfer_start_o      (xfer_start_o),
  .req_pend_o        (req_pend_o)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] int_evt = '0, ext_pin = 4'hF, src_ext = '0, pol_rise = '0, ch_en = '0;
  logic       cpu_done = 1'b0, xfer_done = 1'b0;
  logic [3:0] gnt, pend;
  logic       cpu_gnt, start;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_req_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .int_evt_i(int_evt), .ext_pin_i(ext_pin),
    .src_ext_i(src_ext), .pol_rise_i(pol_rise), .ch_en_i(ch_en),
    .cpu_access_done_i(cpu_done), .dma_xfer_done_i(xfer_done),
    .dma_gnt_o(gnt), .cpu_gnt_o(cpu_gnt), .xfer_start_o(start), .req_pend_o(pend)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // grants every enabled pending channel in ascending order, checking each step
  task automatic drain(input logic [3:0] m, input logic [3:0] e);
    logic [3:0] exp_p, elig, pick;
    exp_p = m;
    ch_en = e;
    while ((exp_p & e) != 4'h0) begin
      elig = exp_p & e;
      pick = elig & (~elig + 4'h1);
      cpu_done = 1'b1; cyc(); cpu_done = 1'b0;
      check("R5 grant", {4'h0, gnt}, {4'h0, pick});
      check("R5 cpu_gnt low", {7'h0, cpu_gnt}, 8'h0);
      check("R6 start", {7'h0, start}, 8'h1);
      exp_p = exp_p & ~pick;
      check("R6 clear", {4'h0, pend}, {4'h0, exp_p});
      cpu_done = 1'b1; cyc(); cpu_done = 1'b0;
      check("R6 start once", {7'h0, start}, 8'h0);
      check("R8 hold", {4'h0, gnt}, {4'h0, pick});
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
      check("R8 return", {3'h0, cpu_gnt, gnt}, 8'h10);
      cyc();
      check("R8 boundary", {3'h0, cpu_gnt, gnt}, 8'h10);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 reset", {gnt, pend}, 8'h00);
    check("R1 reset cpu", {6'h0, cpu_gnt, start}, 8'h2);
    rst_n = 1'b1;
    cyc(4);
    check("R1 after release", {3'h0, cpu_gnt, pend}, 8'h10);

    // R4/R5/R7: every request mask against every enable mask
    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e < 16; e++) begin
        int_evt = m[3:0]; cyc(); int_evt = '0;
        check("R4 latch all", {4'h0, pend}, {4'h0, m[3:0]});
        drain(m[3:0], e[3:0]);
        check("R7 left latched", {4'h0, pend}, {4'h0, m[3:0] & ~e[3:0]});
        cpu_done = 1'b1; cyc(); cpu_done = 1'b0;
        check("R7 never granted", {3'h0, cpu_gnt, gnt}, 8'h10);
        drain(m[3:0] & ~e[3:0], 4'hF);
      end
    end

    // R2: source select masks the other source
    src_ext = 4'hF; int_evt = 4'hF; cyc(); int_evt = '0; cyc(3);
    check("R2 int ignored when ext", {4'h0, pend}, 8'h0);
    src_ext = '0; ext_pin = '0; cyc(4); ext_pin = 4'hF; cyc(4);
    check("R2 pin ignored when int", {4'h0, pend}, 8'h0);

    // R3: both polarities on every channel
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        pol_rise[c] = p[0]; ext_pin[c] = ~p[0]; cyc(4);
        src_ext[c] = 1'b1; cyc(2);
        check("R3 idle", {4'h0, pend}, 8'h0);
        ext_pin[c] = p[0]; cyc(2);
        check("R3 latency", {4'h0, pend}, 8'h0);
        cyc();
        check("R3 edge set", {4'h0, pend}, {4'h0, 4'h1 << c});
        drain(4'h1 << c, 4'hF);
        ext_pin[c] = ~p[0]; cyc(4);
        check("R3 opposite edge", {4'h0, pend}, 8'h0);
        src_ext[c] = 1'b0; ext_pin[c] = 1'b1; pol_rise[c] = 1'b0; cyc(4);
      end
    end

    // R4: two pins falling in the same cycle
    src_ext = 4'b0110; cyc(2);
    ext_pin = 4'b1001; cyc(3);
    check("R4 ext together", {4'h0, pend}, 8'h06);
    drain(4'h6, 4'hF);
    ext_pin = 4'hF; cyc(4); src_ext = '0; cyc();

    // R9: re-trigger on the grant edge and during transfer
    ch_en = 4'hF;
    int_evt = 4'h1; cyc(); int_evt = '0;
    int_evt = 4'h1; cpu_done = 1'b1; cyc(); int_evt = '0; cpu_done = 1'b0;
    check("R9 kept on grant edge", {gnt, pend}, 8'h11);
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    cpu_done = 1'b1; cyc(); cpu_done = 1'b0;
    check("R9 regranted", {gnt, pend}, 8'h10);
    int_evt = 4'h1; cyc(); int_evt = '0;
    check("R9 set in transfer", {gnt, pend}, 8'h11);
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    drain(4'h1, 4'hF);

    // R10: transfer-done while CPU owns the bus
    int_evt = 4'h8; cyc(); int_evt = '0;
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
    check("R10 ignored", {3'h0, cpu_gnt, pend}, 8'h18);
    check("R10 no grant", {4'h0, gnt}, 8'h0);
    drain(4'h8, 4'hF);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule